// File: doc/BRIEF.md
# Write-Unlock Command Sequence Detector

This block sits in front of the page loader of a parallel nonvolatile memory and decides whether each write strobe carries real data or belongs to an attempt that must store nothing. Storage is locked by default. A write cycle stores data only after three code writes arrive in a fixed order: 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555. Code writes are consumed and never stored. The two code addresses are otherwise ordinary locations.

After the third code write, every qualified write is passed to the loader with a one-cycle `data_accept` pulse. This continues until the loader reports the end of the programming cycle on `cycle_done`, and then the lock closes again. A write that breaks the code, a code that stalls between steps, or a write with no code at all produces a one-cycle `dummy_cycle` pulse. The loader runs a full busy period for it but stores nothing. Writes are ignored during that period until `cycle_done`.

A write is considered only when all of these hold: chip enable is asserted, output enable is deasserted, write enable is asserted, and a power-up settling count has elapsed since reset.

Top module: `wr_unlock_detect`

## Requirements
- R1: For the first PWRUP_CYCLES clock edges after reset release, write strobes produce no output pulse and do not advance the code; both outputs are 0 during and right after reset.
- R2: A strobe is ignored while oe_n is 0, ce_n is 1 or we_n is 1 (all three enables are active low levels); it neither pulses an output nor disturbs the code progress.
- R3: The code is data 0xAA at address 0x1555, then 0x55 at 0x0AAA, then 0xA0 at 0x1555; the three code writes pulse neither output.
- R4: Once the code is complete, each qualified write pulses data_accept for one cycle, on the clock edge after the strobe, at any address including 0x1555 and 0x0AAA and with any data.
- R5: A write that does not match the expected step, at any step, pulses dummy_cycle (not data_accept); further writes are ignored until cycle_done.
- R6: A qualified write in the locked state that is not the first code step pulses dummy_cycle.
- R7: Each code step may follow the previous one by at most WINDOW_CYCLES clock edges; if no write arrives within that window after step one or two, dummy_cycle pulses on exactly that edge.
- R8: If the code completes but no data write arrives within WINDOW_CYCLES edges, the block silently returns to the locked state with no pulse.
- R9: cycle_done ends an unlocked or rejected cycle and relocks the block; it takes priority over a strobe on the same edge, so a later write without a new code pulses dummy_cycle.
- R10: data_accept and dummy_cycle are never high together, and each lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active low asynchronous reset |
| wr_strobe | input | 1 | One-cycle pulse per bus write |
| addr | input | 13 | Write address |
| wdata | input | 8 | Write data |
| ce_n | input | 1 | Chip enable level, active low |
| oe_n | input | 1 | Output enable level, active low |
| we_n | input | 1 | Write enable level, active low |
| cycle_done | input | 1 | Loader reports the end of a write cycle |
| data_accept | output | 1 | Pulse: this write is real page data |
| dummy_cycle | output | 1 | Pulse: start a busy cycle that stores nothing |

## Verification
The bench builds the block with WINDOW_CYCLES = 16 and PWRUP_CYCLES = 40. With these values, step timeouts, the exact window boundary and the end of the power-up hold all occur within tens of cycles. The directed part reaches each of these cases explicitly. A random phase then mixes code steps, stray writes, inhibited strobes and cycle_done pulses over thousands of cycles, with every output compared against a bench model of the sequence.

// File: rtl/wr_unlock_pkg.sv
package wr_unlock_pkg;

  localparam int CODE_ADDR_W = 13;
  localparam int CODE_DATA_W = 8;

  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_STEP1,
    ST_STEP2,
    ST_OPEN_EMPTY,
    ST_OPEN_LOADED,
    ST_BUSY
  } ulk_state_e;

  // Which code step (1..3) a write matches; 0 when it matches none.
  function automatic logic [1:0] code_step(input logic [CODE_ADDR_W-1:0] a,
                                           input logic [CODE_DATA_W-1:0] d);
    if (a == 13'h1555 && d == 8'hAA) return 2'd1;
    if (a == 13'h0AAA && d == 8'h55) return 2'd2;
    if (a == 13'h1555 && d == 8'hA0) return 2'd3;
    return 2'd0;
  endfunction

  // Step the detector waits for in a given state.
  function automatic logic [1:0] wanted_step(input ulk_state_e s);
    case (s)
      ST_LOCKED: return 2'd1;
      ST_STEP1:  return 2'd2;
      ST_STEP2:  return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ulk_powerup_gate.sv
module ulk_powerup_gate #(
  parameter int DELAY = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CNT_W = $clog2(DELAY + 2);

  logic [CNT_W-1:0] cnt;

  assign ready = (cnt == CNT_W'(DELAY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!ready) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ulk_gap_timer.sv
module ulk_gap_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ulk_seq_fsm.sv
module ulk_seq_fsm
  import wr_unlock_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   write_ok,
  input  logic [CODE_ADDR_W-1:0] addr,
  input  logic [CODE_DATA_W-1:0] wdata,
  input  logic                   cycle_done,
  input  logic                   gap_expired,
  output logic                   gap_clear,
  output logic                   gap_run,
  output logic                   waiting,
  output logic                   data_accept,
  output logic                   dummy_cycle
);
  ulk_state_e st, st_nx;
  logic       acc_nx, dum_nx;
  logic [1:0] step;
  logic       step_ok;

  assign step    = code_step(addr, wdata);
  assign step_ok = (step == wanted_step(st));
  assign waiting = (st == ST_STEP1) || (st == ST_STEP2);
  assign gap_run = waiting || (st == ST_OPEN_EMPTY);

  always_comb begin
    st_nx     = st;
    acc_nx    = 1'b0;
    dum_nx    = 1'b0;
    gap_clear = 1'b0;
    case (st)
      ST_LOCKED, ST_STEP1, ST_STEP2: begin
        if (write_ok) begin
          if (step_ok) begin
            gap_clear = 1'b1;
            st_nx = (st == ST_LOCKED) ? ST_STEP1 :
                    (st == ST_STEP1)  ? ST_STEP2 : ST_OPEN_EMPTY;
          end else begin
            dum_nx = 1'b1;
            st_nx  = ST_BUSY;
          end
        end else if (waiting && gap_expired) begin
          dum_nx = 1'b1;
          st_nx  = ST_BUSY;
        end
      end
      ST_OPEN_EMPTY: begin
        if (cycle_done)       st_nx = ST_LOCKED;
        else if (write_ok) begin
          acc_nx = 1'b1;
          st_nx  = ST_OPEN_LOADED;
        end else if (gap_expired) st_nx = ST_LOCKED;
      end
      ST_OPEN_LOADED: begin
        if (cycle_done)    st_nx  = ST_LOCKED;
        else if (write_ok) acc_nx = 1'b1;
      end
      ST_BUSY: begin
        if (cycle_done) st_nx = ST_LOCKED;
      end
      default: st_nx = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_LOCKED;
      data_accept <= 1'b0;
      dummy_cycle <= 1'b0;
    end else begin
      st          <= st_nx;
      data_accept <= acc_nx;
      dummy_cycle <= dum_nx;
    end
  end

  // R10: the two verdicts exclude each other
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_accept && dummy_cycle));

  // R4: data is accepted only out of an unlocked state
  a_r4_accept_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |-> $past(st == ST_OPEN_EMPTY || st == ST_OPEN_LOADED));

  // R3: the final code write is consumed silently
  a_r3_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (write_ok && st == ST_STEP2 && step == 2'd3) |=> (!data_accept && !dummy_cycle));

  // R5: a rejected cycle stays quiet until it ends
  a_r5_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY && !cycle_done) |=> (!data_accept && !dummy_cycle));

endmodule

// File: rtl/wr_unlock_detect.sv
module wr_unlock_detect
  import wr_unlock_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1000,
  parameter int PWRUP_CYCLES  = 100000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_strobe,
  input  logic [CODE_ADDR_W-1:0] addr,
  input  logic [CODE_DATA_W-1:0] wdata,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   we_n,
  input  logic                   cycle_done,
  output logic                   data_accept,
  output logic                   dummy_cycle
);
  logic pwr_ready;
  logic inhibit;
  logic write_ok;
  logic gap_clear, gap_run, gap_expired;
  logic waiting;

  assign inhibit  = !oe_n || ce_n || we_n;
  assign write_ok = wr_strobe && !inhibit && pwr_ready;

  ulk_powerup_gate #(.DELAY(PWRUP_CYCLES)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (pwr_ready)
  );

  ulk_gap_timer #(.LIMIT(WINDOW_CYCLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (gap_clear),
    .run     (gap_run),
    .expired (gap_expired)
  );

  ulk_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .write_ok    (write_ok),
    .addr        (addr),
    .wdata       (wdata),
    .cycle_done  (cycle_done),
    .gap_expired (gap_expired),
    .gap_clear   (gap_clear),
    .gap_run     (gap_run),
    .waiting     (waiting),
    .data_accept (data_accept),
    .dummy_cycle (dummy_cycle)
  );

  // R1: nothing comes out of a strobe seen before the settling count ends
  a_r1_powerup_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ready |=> (!data_accept && !dummy_cycle));

  // R2: an inhibited strobe, outside a step window, yields no pulse
  a_r2_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && inhibit && !waiting) |=> (!data_accept && !dummy_cycle));

endmodule

// File: tb/wr_unlock_detect_tb.sv
module wr_unlock_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int PW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_strobe = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0;
  logic cycle_done = 1'b0;
  logic data_accept, dummy_cycle;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_unlock_detect #(.WINDOW_CYCLES(W), .PWRUP_CYCLES(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .addr(addr), .wdata(wdata),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .cycle_done(cycle_done),
    .data_accept(data_accept), .dummy_cycle(dummy_cycle));

  // Bench model of the requirements: 0 locked, 1 and 2 code steps seen,
  // 3 unlocked without data, 4 unlocked with data, 5 rejected cycle.
  int  m_phase = 0;
  int  m_gap   = 0;
  int  m_pw    = 0;
  bit  m_acc   = 0;
  bit  m_dum   = 0;

  function automatic int step_of(input logic [12:0] a, input logic [7:0] d);
    if (a == 13'h1555) return (d == 8'hAA) ? 1 : (d == 8'hA0) ? 3 : 0;
    if (a == 13'h0AAA && d == 8'h55) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_gap = 0; m_pw = 0; m_acc = 0; m_dum = 0;
    end else begin
      bit q;
      int s;
      q = wr_strobe && !ce_n && oe_n && !we_n && (m_pw == PW);
      if (m_pw < PW) m_pw++;
      s = step_of(addr, wdata);
      m_acc = 0; m_dum = 0;
      if (m_phase <= 2) begin
        if (q) begin
          if (s == m_phase + 1) begin m_phase++; m_gap = 0; end
          else begin m_dum = 1; m_phase = 5; end
        end else if (m_phase > 0) begin
          if (m_gap == W - 1) begin m_dum = 1; m_phase = 5; end
          else m_gap++;
        end
      end else if (m_phase == 3) begin
        if (cycle_done) m_phase = 0;
        else if (q) begin m_acc = 1; m_phase = 4; end
        else if (m_gap == W - 1) m_phase = 0;
        else m_gap++;
      end else if (m_phase == 4) begin
        if (cycle_done) m_phase = 0;
        else if (q) m_acc = 1;
      end else begin
        if (cycle_done) m_phase = 0;
      end
    end
  end

  // R10: model comparison on every cycle after reset
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (data_accept !== m_acc || dummy_cycle !== m_dum) begin
        errors++;
        $display("FAIL R10 model: acc/dum actual %b%b expected %b%b at %0t",
                 data_accept, dummy_cycle, m_acc, m_dum, $time);
      end
    end
  end

  task automatic chk(input string tag, input bit ea, input bit ed);
    checks++;
    if (data_accept !== ea || dummy_cycle !== ed) begin
      errors++;
      $display("FAIL %s: acc/dum actual %b%b expected %b%b at %0t",
               tag, data_accept, dummy_cycle, ea, ed, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d,
                    input bit c = 0, input bit o = 1, input bit w = 0);
    addr = a; wdata = d; ce_n = c; oe_n = o; we_n = w; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
  endtask

  task automatic done_pulse();
    cycle_done = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic code(input string tag);
    wr(13'h1555, 8'hAA); chk(tag, 0, 0);
    wr(13'h0AAA, 8'h55); chk(tag, 0, 0);
    wr(13'h1555, 8'hA0); chk(tag, 0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R10 watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    tick(3);
    chk("R1 reset state", 0, 0);
    rst_n = 1'b1;
    tick(2);
    wr(13'h1555, 8'hAA); chk("R1 early write", 0, 0);
    wr(13'h0222, 8'h12); chk("R1 early write", 0, 0);
    tick(PW + 5);

    // R2 inhibited strobes, then a clean code still works
    wr(13'h0100, 8'h01, 0, 0, 0); chk("R2 oe low", 0, 0);
    wr(13'h0100, 8'h01, 1, 1, 0); chk("R2 ce high", 0, 0);
    wr(13'h0100, 8'h01, 0, 1, 1); chk("R2 we high", 0, 0);
    code("R3 code silent");
    wr(13'h0123, 8'h5A); chk("R4 data", 1, 0);
    wr(13'h1555, 8'h77); chk("R4 code address as data", 1, 0);
    wr(13'h0AAA, 8'h55); chk("R4 code value as data", 1, 0);
    done_pulse(); chk("R9 done", 0, 0);
    wr(13'h0200, 8'h11); chk("R9 relocked", 0, 1);
    wr(13'h1555, 8'hAA); chk("R5 busy ignores", 0, 0);
    done_pulse();

    // R6 lone write
    wr(13'h0300, 8'hAA); chk("R6 no code", 0, 1);
    done_pulse();

    // R5 mismatch at step two and step three
    wr(13'h1555, 8'hAA); chk("R5 step1", 0, 0);
    wr(13'h0AAA, 8'h54); chk("R5 bad step2", 0, 1);
    done_pulse();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
    wr(13'h1555, 8'hA1); chk("R5 bad step3", 0, 1);
    done_pulse();
    wr(13'h1555, 8'hAA); wr(13'h1555, 8'hAA); chk("R5 repeated step1", 0, 1);
    done_pulse();

    // R7 window boundary accepted, then exceeded
    wr(13'h1555, 8'hAA);
    tick(W - 1);
    wr(13'h0AAA, 8'h55); chk("R7 gap at limit", 0, 0);
    wr(13'h1555, 8'hA0); chk("R7 gap at limit", 0, 0);
    wr(13'h0444, 8'h3C); chk("R7 unlocked after slow code", 1, 0);
    done_pulse();
    wr(13'h1555, 8'hAA);
    tick(W - 1); chk("R7 before expiry", 0, 0);
    tick(1);     chk("R7 expiry", 0, 1);
    done_pulse();

    // R8 unlocked but idle
    code("R8 code");
    tick(W); chk("R8 silent timeout", 0, 0);
    tick(2);
    wr(13'h0500, 8'h44); chk("R8 relocked", 0, 1);
    done_pulse();

    // R9 done beats a same-cycle strobe
    code("R9 code");
    cycle_done = 1'b1; addr = 13'h0600; wdata = 8'h66; wr_strobe = 1'b1;
    @(negedge clk);
    cycle_done = 1'b0; wr_strobe = 1'b0;
    chk("R9 done priority", 0, 0);
    wr(13'h0600, 8'h66); chk("R9 needs new code", 0, 1);
    done_pulse();

    // Random phase, checked against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cycle_done = ($urandom_range(0, 99) < 4);
      wr_strobe  = (r < 35);
      case ($urandom_range(0, 4))
        0: begin addr = 13'h1555; wdata = 8'hAA; end
        1: begin addr = 13'h0AAA; wdata = 8'h55; end
        2: begin addr = 13'h1555; wdata = 8'hA0; end
        default: begin addr = 13'($urandom); wdata = 8'($urandom); end
      endcase
      ce_n = ($urandom_range(0, 19) == 0);
      oe_n = ($urandom_range(0, 19) != 0);
      we_n = ($urandom_range(0, 19) == 0);
      @(negedge clk);
    end
    wr_strobe = 1'b0; cycle_done = 1'b0;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    tick(2);
    finish_run();
  end

endmodule